// File: doc/BRIEF.md
# CAN Controller Stop-Mode Sequencer

This block controls how a CAN protocol controller enters and leaves its low-power stop state. Software asks for stop through a bit in a small control register. The sequencer then waits for a point where stopping cannot corrupt bus traffic: either the bus is idle, or the controller is in intermission at the third bit and the synchronized receive line is recessive. After that it waits for the core to report that its internal work has drained, and only then does it turn off the protocol core's clock enable.

While stopped, the core sees a recessive receive line and the transmit pin is held recessive. Two flags report the state to software: a stop acknowledge and a not-ready flag. The host register port runs on the always-on clock, and so does a two-stage receive synchronizer feeding a falling-edge detector. A recessive-to-dominant edge on the bus while stopped therefore latches a wake status bit, and that bit drives an interrupt when the wake mask is set. Software can leave stop by clearing the stop request. It can also clear everything with a soft-reset write, and a hard reset does the same. Clearing the request also cancels an entry that has not finished yet.

On exit the clock comes back and the acknowledge drops at once. Not-ready stays set until the core reports that it has re-synchronized to the bus.

Top module: `can_stop_seq`

## Requirements
- R1: Writing the control register (reg_addr 0) with bit 0 set raises the stop request. Until stop is reached, the clock enable stays 1, tx_pin follows core_tx, and stop_ack and not_ready stay 0.
- R2: Entry continues past the bus check only when bus_idle is 1, or when intermission is 1 with intm_bit equal to 2 (the third bit, counted from 0) and the synchronized rx_pin is 1. With the third bit dominant, the block does not stop.
- R3: After the bus check, stop is reached only on a clock where core_busy is 0.
- R4: In stop, core_clk_en is 0, tx_pin is 1 and rx_core is 1 whatever rx_pin and core_tx are. Outside stop, core_clk_en is 1, tx_pin equals core_tx and rx_core equals rx_pin.
- R5: In stop, stop_ack and not_ready are both 1. A control read (rd_addr 0) returns {not_ready, stop_ack, wake_mask, 0, stop_request} in bits 4 down to 0.
- R6: Clearing the stop request while stopped turns the clock enable back on and clears stop_ack on the next clock. not_ready stays 1 until a clock with sync_done at 1.
- R7: Clearing the stop request while entry is still waiting on the bus or on the drain returns the block to normal operation without gating the clock.
- R8: A control write with bit 1 set is a soft reset. It clears the stop request, the wake mask, the wake status and both flags, and returns to normal operation on that clock.
- R9: While stopped, a 1-to-0 transition of rx_pin sets the wake status (status read, rd_addr 1, bit 0) on the third clock edge after the change. The same transition outside stop leaves the status at 0.
- R10: wake_irq is 1 exactly when the wake status is set and the wake mask (control bit 2) is 1.
- R11: Writing the status register (reg_addr 1) with bit 0 set clears the wake status. When a new wake edge arrives on the same clock, the status stays set.
- R12: Hard reset (rst_n low) returns the block to normal operation with every register and flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock for the host port and sequencer |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 1 | Write target: 0 control, 1 status |
| reg_wdata | input | 5 | Write data |
| rd_addr | input | 1 | Read select: 0 control, 1 status |
| rd_data | output | 5 | Read data |
| bus_idle | input | 1 | Protocol engine reports an idle bus |
| intermission | input | 1 | Protocol engine is in intermission |
| intm_bit | input | 2 | Index of the current intermission bit |
| core_busy | input | 1 | Internal work outside the bus interface is pending |
| sync_done | input | 1 | Core has re-synchronized to the bus after stop |
| rx_pin | input | 1 | Receive line from the transceiver |
| core_tx | input | 1 | Transmit value produced by the core |
| core_clk_en | output | 1 | Clock-gate enable for the protocol core |
| tx_pin | output | 1 | Transmit line to the transceiver |
| rx_core | output | 1 | Receive value presented to the core |
| stop_ack | output | 1 | Stop acknowledge flag |
| not_ready | output | 1 | Core not synchronized to the bus |
| wake_irq | output | 1 | Wake interrupt request |

## Verification
On every clock, the assertions check the following. Stop is never reached unless the bus was safe when the bus check was passed and the core was idle on the entry clock. The pin overrides and both flags hold whenever the clock is gated. The acknowledge and not-ready flags fall only after a cleared request, a completed resync or a soft reset. Wake status rises only from the stopped state, and a status clear without a coincident wake edge takes effect. Only the bench scenarios can show the rest: the exact cycle of each transition, the abort paths, the dominant third bit holding entry off, the three-edge wake latency, the set-over-clear race, and the register readback after soft and hard reset.

// File: rtl/can_stop_seq.sv
module can_stop_seq #(
  parameter int unsigned IBW         = 2,
  parameter logic [IBW-1:0] SAFE_BIT = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_addr,
  input  logic [4:0]     reg_wdata,
  input  logic           rd_addr,
  output logic [4:0]     rd_data,
  input  logic           bus_idle,
  input  logic           intermission,
  input  logic [IBW-1:0] intm_bit,
  input  logic           core_busy,
  input  logic           sync_done,
  input  logic           rx_pin,
  input  logic           core_tx,
  output logic           core_clk_en,
  output logic           tx_pin,
  output logic           rx_core,
  output logic           stop_ack,
  output logic           not_ready,
  output logic           wake_irq
);

  typedef enum logic [2:0] {NORMAL, WAIT_BUS, WAIT_DRAIN, STOPPED, EXITING} st_t;

  st_t state, state_nx;
  logic stop_req, wake_mask, wake_pend;
  logic [SYNC_STAGES-1:0] rx_sync;
  logic rx_prev;

  wire ctrl_wr  = reg_wr & ~reg_addr;
  wire stat_wr  = reg_wr & reg_addr;
  wire soft_rst = ctrl_wr & reg_wdata[1];
  wire rx_s     = rx_sync[SYNC_STAGES-1];
  wire in_stop  = (state == STOPPED);
  wire bus_safe = bus_idle | (intermission & (intm_bit == SAFE_BIT) & rx_s);
  wire wake_set = in_stop & rx_prev & ~rx_s;
  wire wake_clr = stat_wr & reg_wdata[0];

  assign core_clk_en = ~in_stop;
  assign tx_pin      = in_stop ? 1'b1 : core_tx;
  assign rx_core     = in_stop ? 1'b1 : rx_pin;
  assign stop_ack    = in_stop;
  assign not_ready   = in_stop | (state == EXITING);
  assign wake_irq    = wake_pend & wake_mask;
  assign rd_data     = rd_addr ? {4'b0000, wake_pend}
                               : {not_ready, stop_ack, wake_mask, 1'b0, stop_req};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= '1;
      rx_prev <= 1'b1;
    end else begin
      rx_sync <= {rx_sync[SYNC_STAGES-2:0], rx_pin};
      rx_prev <= rx_s;
    end
  end

  always_comb begin
    state_nx = state;
    case (state)
      NORMAL:     if (stop_req) state_nx = WAIT_BUS;
      WAIT_BUS:   if (!stop_req) state_nx = NORMAL;
                  else if (bus_safe) state_nx = WAIT_DRAIN;
      WAIT_DRAIN: if (!stop_req) state_nx = NORMAL;
                  else if (!core_busy) state_nx = STOPPED;
      STOPPED:    if (!stop_req) state_nx = EXITING;
      EXITING:    if (sync_done) state_nx = NORMAL;
      default:    state_nx = NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= NORMAL;
      stop_req  <= 1'b0;
      wake_mask <= 1'b0;
      wake_pend <= 1'b0;
    end else if (soft_rst) begin
      state     <= NORMAL;
      stop_req  <= 1'b0;
      wake_mask <= 1'b0;
      wake_pend <= 1'b0;
    end else begin
      state     <= state_nx;
      wake_pend <= wake_set | (wake_pend & ~wake_clr);
      if (ctrl_wr) begin
        stop_req  <= reg_wdata[0];
        wake_mask <= reg_wdata[2];
      end
    end
  end

  assert_bus_safe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAIT_DRAIN && $past(state) == WAIT_BUS) |-> $past(bus_safe));

  assert_drained_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack) |-> $past(!core_busy));

  assert_stop_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> (tx_pin && rx_core && stop_ack && not_ready));

  assert_exit_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_ack) |-> ($past(!stop_req) || $past(soft_rst)));

  assert_ready_after_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(not_ready) |-> ($past(sync_done) || $past(soft_rst)));

  assert_wake_only_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pend) |-> $past(in_stop));

  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wake_clr) && !$past(wake_set)) |-> !wake_pend);

endmodule

// File: tb/can_stop_seq_bench.sv
module can_stop_seq_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_addr = 0, rd_addr = 0;
  logic [4:0] reg_wdata = 0, rd_data;
  logic bus_idle = 0, intermission = 0, core_busy = 1, sync_done = 0;
  logic [1:0] intm_bit = 0;
  logic rx_pin = 1, core_tx = 0;
  logic core_clk_en, tx_pin, rx_core, stop_ack, not_ready, wake_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_stop_seq u_can_stop_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .bus_idle(bus_idle), .intermission(intermission), .intm_bit(intm_bit),
    .core_busy(core_busy), .sync_done(sync_done), .rx_pin(rx_pin),
    .core_tx(core_tx), .core_clk_en(core_clk_en), .tx_pin(tx_pin),
    .rx_core(rx_core), .stop_ack(stop_ack), .not_ready(not_ready),
    .wake_irq(wake_irq));

  // wr wd[2:0] idle intm ibit[1:0] busy sync ctx | clk_en tx ack nr
  localparam logic [14:0] VEC [0:21] = '{
    15'b1_001_0_0_00_1_0_0_1000,
    15'b0_000_0_0_00_1_0_0_1000,
    15'b0_000_0_1_01_1_0_0_1000,
    15'b0_000_0_1_10_1_0_0_1000,
    15'b0_000_0_0_00_1_0_0_1000,
    15'b0_000_0_0_00_0_0_0_0111,
    15'b0_000_0_0_00_1_0_0_0111,
    15'b1_000_0_0_00_1_0_0_0111,
    15'b0_000_0_0_00_1_0_0_1001,
    15'b0_000_0_0_00_1_0_0_1001,
    15'b0_000_0_0_00_1_1_0_1000,
    15'b1_001_0_0_00_1_0_0_1000,
    15'b0_000_0_0_00_1_0_0_1000,
    15'b1_000_0_0_00_1_0_0_1000,
    15'b0_000_1_0_00_0_0_0_1000,
    15'b0_000_1_0_00_0_0_0_1000,
    15'b1_001_0_0_00_1_0_0_1000,
    15'b0_000_1_0_00_1_0_0_1000,
    15'b0_000_1_0_00_1_0_0_1000,
    15'b1_000_1_0_00_1_0_0_1000,
    15'b0_000_1_0_00_0_0_0_1000,
    15'b0_000_1_0_00_0_0_0_1000
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [4:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R12 reset outputs", {core_clk_en, stop_ack, not_ready, wake_irq}, 4'b1000);
    check("R12 reset control read", rd_data, 5'b00000);

    for (int i = 0; i < 22; i++) begin
      reg_wr = VEC[i][14]; reg_addr = 0; reg_wdata = {2'b00, VEC[i][13:11]};
      bus_idle = VEC[i][10]; intermission = VEC[i][9]; intm_bit = VEC[i][8:7];
      core_busy = VEC[i][6]; sync_done = VEC[i][5]; core_tx = VEC[i][4];
      @(posedge clk); @(negedge clk);
      reg_wr = 0;
      check($sformatf("R1 R2 R3 R4 R5 R6 R7 row %0d", i),
            {core_clk_en, tx_pin, stop_ack, not_ready}, VEC[i][3:0]);
    end
    sync_done = 0;

    // R4 pass-through outside stop; R9 no wake outside stop
    core_tx = 1; rx_pin = 0; #1;
    check("R4 rx pass-through", rx_core, 1'b0);
    check("R4 tx pass-through", tx_pin, 1'b1);
    cycles(4);
    rd_addr = 1; #1;
    check("R9 no wake outside stop", rd_data, 5'b00000);
    core_tx = 0;

    // R2 dominant third intermission bit holds entry off
    bus_idle = 0; intermission = 1; intm_bit = 2; core_busy = 0;
    host_wr(0, 5'b00001);
    cycles(5);
    check("R2 dominant third bit blocks stop", {core_clk_en, stop_ack}, 2'b10);
    rx_pin = 1;
    cycles(6);
    check("R2 recessive third bit allows stop", {core_clk_en, stop_ack, not_ready}, 3'b011);
    rx_pin = 0; #1;
    check("R4 rx forced recessive", {rx_core, tx_pin}, 2'b11);
    repeat (3) @(posedge clk);
    @(negedge clk); rd_addr = 1; #1;
    check("R9 wake status set in stop", rd_data, 5'b00001);
    check("R10 irq masked", wake_irq, 1'b0);
    rd_addr = 0; #1;
    check("R5 control readback in stop", rd_data, 5'b11001);

    host_wr(0, 5'b00101); #1;
    check("R10 irq unmasked", wake_irq, 1'b1);
    host_wr(1, 5'b00001); rd_addr = 1; #1;
    check("R11 w1c clears status", {wake_irq, rd_data}, 6'b000000);
    rx_pin = 1;
    cycles(4);

    // R11 set wins over simultaneous clear
    rx_pin = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_addr = 1; reg_wdata = 5'b00001; reg_wr = 1;
    @(posedge clk); @(negedge clk);
    reg_wr = 0; rd_addr = 1; #1;
    check("R11 set wins over clear", rd_data, 5'b00001);

    // R8 soft reset from stop
    host_wr(0, 5'b00010); #1;
    check("R8 soft reset outputs", {core_clk_en, stop_ack, not_ready, wake_irq}, 4'b1000);
    check("R8 soft reset status", rd_data, 5'b00000);
    rd_addr = 0; #1;
    check("R8 soft reset control", rd_data, 5'b00000);

    // R12 hard reset from stop
    rx_pin = 1; bus_idle = 1; intermission = 0; core_busy = 0;
    host_wr(0, 5'b00101);
    cycles(4);
    check("R1 stop reached on idle bus", {core_clk_en, stop_ack}, 2'b01);
    rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    check("R12 hard reset outputs", {core_clk_en, stop_ack, not_ready, wake_irq}, 4'b1000);
    check("R12 hard reset control", rd_data, 5'b00000);
    cycles(2);
    check("R12 stays normal", {core_clk_en, stop_ack}, 2'b10);

    done = 1;
    summary();
    $finish;
  end
endmodule